// File: doc/BRIEF.md
# Oversampled I2S Loopback Transceiver

This block receives and retransmits an I2S audio stream as a bus slave. It runs entirely from one fast system clock and never uses the serial bit clock as a clock. The bit clock, word-select and serial data lines are sampled as ordinary data through a synchronizer. Bit-clock edges are then found by comparing each synchronized sample with the one from the previous system cycle.

On each detected rising edge the receiver shifts one serial bit into a 16-bit word. A word-select change closes the word and hands it to the register of the channel that just ended. After the right word of a frame lands, a one-cycle strobe is raised.

The transmitter shifts out on detected falling edges. For each slot it sends the word most recently captured for that slot's channel, so the output stream repeats the input stream one frame later. Every word-select edge restarts both shifters. A lost or extra bit-clock edge therefore spoils at most one word.

Top module: `i2s_loopback`

## Requirements
- R1: While `rst_ni` is low, and after its release until bit-clock edges arrive, `sd_o`, `valid_o`, `left_o` and `right_o` are all zero.
- R2: A slot with word-select low is stored in `left_o`, and one with word-select high is stored in `right_o`. Bits arrive MSB first, and the MSB is sampled on the second detected bit-clock rising edge after a word-select change. With 16 bit clocks per slot, the LSB is sampled on the rising edge at which the next word-select change is seen.
- R3: `valid_o` is high for exactly one system cycle per frame, shortly after the right word completes. In that cycle `left_o` and `right_o` hold that frame's pair.
- R4: In a slot longer than 16 bit clocks, only the first 16 data bits are kept and later bits are ignored.
- R5: During every slot, `sd_o` carries the word last captured for that slot's channel, MSB first. Data bit k of the slot (counting from 0) is driven from the (k+1)-th detected falling edge after the word-select change. Positions 16 and later in a slot are driven as zero.
- R6: While the bit clock does not toggle, changes on word-select or serial data leave `sd_o`, `left_o`, `right_o` and `valid_o` unchanged.
- R7: A slot of N < 16 bit clocks yields the first N bits of the word, right-aligned (the sent word shifted right by 16-N). Words that follow are received correctly.
- R8: Bits received before the first word-select change after reset are discarded. No channel register is written and no strobe is raised for them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all state is clocked by it |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| bclk_i | input | 1 | Asynchronous serial bit clock, sampled as data |
| ws_i | input | 1 | Asynchronous word select: 0 = left, 1 = right |
| sd_i | input | 1 | Asynchronous serial data in |
| sd_o | output | 1 | Serial data out (loopback stream) |
| left_o | output | SAMPLE_W | Last complete left word |
| right_o | output | SAMPLE_W | Last complete right word |
| valid_o | output | 1 | One-cycle strobe after a right word completes |

## Verification
The bench builds the block with its defaults: SAMPLE_W = 16 and SYNC_STAGES = 2, with each bit-clock half period set to eight system cycles. A 16-bit word then exactly fills a 16-bit-clock slot, which exercises the case where the LSB is taken on the same rising edge that sees the word-select change. The bench also uses 24- and 32-clock slots, which drive the 5-bit position counter into saturation, and a 10-clock slot, which exercises early re-alignment. The two-stage synchronizer plus the edge register stay well inside one bit-clock half period, so every transmitted bit can be checked just before the next rising edge.

// File: rtl/i2s_lb_pkg.sv
package i2s_lb_pkg;
  typedef struct packed {
    logic bclk;
    logic ws;
    logic sd;
  } i2s_lines_t;

  localparam int LINE_W = $bits(i2s_lines_t);
endpackage

// File: rtl/i2s_lb_sync.sv
module i2s_lb_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q, stage_d;

  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2s_lb_edge.sv
module i2s_lb_edge
  import i2s_lb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  i2s_lines_t lines_i,
  output logic       rise_o,
  output logic       fall_o
);
  logic bclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_prev_q <= 1'b0;
    else         bclk_prev_q <= lines_i.bclk;
  end

  assign rise_o =  lines_i.bclk & ~bclk_prev_q;
  assign fall_o = ~lines_i.bclk &  bclk_prev_q;
endmodule

// File: rtl/i2s_lb_rx.sv
module i2s_lb_rx #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rise_i,
  input  logic         ws_i,
  input  logic         sd_i,
  output logic         slot_start_o,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic             primed_q, primed_d;
  logic             aligned_q, aligned_d;
  logic             ws_last_q, ws_last_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic [W-1:0]     shift_q, shift_d;
  logic [W-1:0]     left_q, left_d, right_q, right_d;
  logic             valid_q, valid_d;
  logic [W-1:0]     word_done;

  assign slot_start_o = rise_i & primed_q & (ws_i != ws_last_q);
  assign word_done    = (pos_q < FULL) ? {shift_q[W-2:0], sd_i} : shift_q;

  always_comb begin
    primed_d  = primed_q;
    aligned_d = aligned_q;
    ws_last_d = ws_last_q;
    pos_d     = pos_q;
    shift_d   = shift_q;
    left_d    = left_q;
    right_d   = right_q;
    valid_d   = 1'b0;
    if (rise_i) begin
      if (!primed_q) begin
        primed_d  = 1'b1;
        ws_last_d = ws_i;
        pos_d     = '0;
        shift_d   = '0;
      end else if (slot_start_o) begin
        if (aligned_q) begin
          if (ws_last_q) begin
            right_d = word_done;
            valid_d = 1'b1;
          end else begin
            left_d = word_done;
          end
        end
        aligned_d = 1'b1;
        ws_last_d = ws_i;
        pos_d     = '0;
        shift_d   = '0;
      end else if (pos_q < FULL) begin
        shift_d = {shift_q[W-2:0], sd_i};
        pos_d   = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q  <= 1'b0;
      aligned_q <= 1'b0;
      ws_last_q <= 1'b0;
      pos_q     <= '0;
      shift_q   <= '0;
      left_q    <= '0;
      right_q   <= '0;
      valid_q   <= 1'b0;
    end else begin
      primed_q  <= primed_d;
      aligned_q <= aligned_d;
      ws_last_q <= ws_last_d;
      pos_q     <= pos_d;
      shift_q   <= shift_d;
      left_q    <= left_d;
      right_q   <= right_d;
      valid_q   <= valid_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/i2s_lb_tx.sv
module i2s_lb_tx #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fall_i,
  input  logic         load_i,
  input  logic [W-1:0] load_word_i,
  output logic         sd_o
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [W-1:0]     shift_q, shift_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic             sd_q, sd_d;

  always_comb begin
    shift_d = shift_q;
    pos_d   = pos_q;
    sd_d    = sd_q;
    if (load_i) begin
      shift_d = load_word_i;
      pos_d   = '0;
    end else if (fall_i) begin
      if (pos_q < FULL) begin
        sd_d    = shift_q[W-1];
        shift_d = {shift_q[W-2:0], 1'b0};
        pos_d   = pos_q + 1'b1;
      end else begin
        sd_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      pos_q   <= '0;
      sd_q    <= 1'b0;
    end else begin
      shift_q <= shift_d;
      pos_q   <= pos_d;
      sd_q    <= sd_d;
    end
  end

  assign sd_o = sd_q;
endmodule

// File: rtl/i2s_loopback.sv
module i2s_loopback
  import i2s_lb_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                ws_i,
  input  logic                sd_i,
  output logic                sd_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic [1:0]    rst_pipe_q;
  logic          rst_int_n;
  i2s_lines_t    raw_lines, sync_lines;
  logic          bclk_rise, bclk_fall, slot_start;
  logic [SAMPLE_W-1:0] tx_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign raw_lines = '{bclk: bclk_i, ws: ws_i, sd: sd_i};

  i2s_lb_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .async_i(raw_lines),
    .sync_o (sync_lines)
  );

  i2s_lb_edge edge_i (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .lines_i(sync_lines),
    .rise_o (bclk_rise),
    .fall_o (bclk_fall)
  );

  i2s_lb_rx #(.W(SAMPLE_W)) rx_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .rise_i      (bclk_rise),
    .ws_i        (sync_lines.ws),
    .sd_i        (sync_lines.sd),
    .slot_start_o(slot_start),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (valid_o)
  );

  assign tx_word = sync_lines.ws ? right_o : left_o;

  i2s_lb_tx #(.W(SAMPLE_W)) tx_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .fall_i     (bclk_fall),
    .load_i     (slot_start),
    .load_word_i(tx_word),
    .sd_o       (sd_o)
  );
endmodule

// File: rtl/i2s_loopback_chk.sv
module i2s_loopback_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         rise_i,
  input logic         fall_i,
  input logic         sd_i,
  input logic [W-1:0] left_i,
  input logic [W-1:0] right_i,
  input logic         valid_i
);
  // R3
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  // R3
  valid_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(rise_i));

  // R2 R6
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rise_i) |-> ($stable(left_i) && $stable(right_i)));

  // R5 R6
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(fall_i) |-> $stable(sd_i));
endmodule

bind i2s_loopback i2s_loopback_chk #(.W(SAMPLE_W)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rise_i (bclk_rise),
  .fall_i (bclk_fall),
  .sd_i   (sd_o),
  .left_i (left_o),
  .right_i(right_o),
  .valid_i(valid_o)
);

// File: tb/i2s_loopback_tb_top.sv
module i2s_loopback_tb_top;
  localparam int W    = 16;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bclk, ws, sd;
  logic sd_o, valid;
  logic [W-1:0] left, right;

  i2s_loopback #(.SAMPLE_W(W), .SYNC_STAGES(2)) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .bclk_i (bclk),
    .ws_i   (ws),
    .sd_i   (sd),
    .sd_o   (sd_o),
    .left_o (left),
    .right_o(right),
    .valid_o(valid)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [2*W-1:0] exp_q[$];
  logic [W-1:0] model_l, model_r;
  logic rx_carry, tx_carry;
  logic prev_valid;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid && prev_valid) check("R3 strobe longer than one cycle", 1, 0);
      if (valid) begin
        if (exp_q.size() == 0) begin
          check("R3/R8 unexpected strobe", 1, 0);
        end else begin
          logic [2*W-1:0] e;
          e = exp_q.pop_front();
          check("R2/R4/R7 left word", 32'(left), 32'(e[2*W-1:W]));
          check("R2/R4 right word", 32'(right), 32'(e[W-1:0]));
        end
      end
      prev_valid = valid;
    end else begin
      prev_valid = 1'b0;
    end
  end

  // Drives one slot of nb bit clocks; checks the transmitted bits (R5)
  task automatic drive_slot(input logic ch, input logic [W-1:0] word, input int nb,
                            input logic [W-1:0] txw);
    for (int p = 0; p < nb; p++) begin
      bclk = 1'b0;
      ws   = ch;
      if (p == 0) sd = rx_carry;
      else        sd = (p - 1 < W) ? word[W-p] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (p == 0) check("R5 tx last bit of slot", 32'(sd_o), 32'(tx_carry));
      else        check("R5 tx data bit", 32'(sd_o), (p - 1 < W) ? 32'(txw[W-p]) : 32'd0);
      bclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    rx_carry = (nb <= W) ? word[W-nb] : 1'b0;
    tx_carry = (nb <= W) ? txw[W-nb]  : 1'b0;
  endtask

  task automatic send_frame(input logic [W-1:0] l, input logic [W-1:0] r,
                            input int nbl, input int nbr);
    drive_slot(1'b0, l, nbl, model_l);
    model_l = (nbl >= W) ? l : (l >> (W - nbl));
    drive_slot(1'b1, r, nbr, model_r);
    model_r = (nbr >= W) ? r : (r >> (W - nbr));
    exp_q.push_back({model_l, model_r});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic so_before;
    logic [W-1:0] l_before, r_before;
    rst_n = 1'b0; bclk = 1'b1; ws = 1'b1; sd = 1'b0;
    model_l = '0; model_r = '0; rx_carry = 1'b0; tx_carry = 1'b0; prev_valid = 1'b0;
    repeat (6) @(negedge clk);
    // R1 outputs held at zero in reset
    check("R1 sd_o in reset", 32'(sd_o), 0);
    check("R1 valid in reset", 32'(valid), 0);
    check("R1 left in reset", 32'(left), 0);
    check("R1 right in reset", 32'(right), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 sd_o after release", 32'(sd_o), 0);
    check("R1 right after release", 32'(right), 0);

    // R8 partial right slot before the first word-select change
    drive_slot(1'b1, 16'hFFFF, 5, '0);
    drive_slot(1'b0, 16'hA5A5, 16, model_l);
    check("R8 partial slot discarded", 32'(right), 0);
    model_l = 16'hA5A5;
    drive_slot(1'b1, 16'h3C3C, 16, model_r);
    model_r = 16'h3C3C;
    exp_q.push_back({model_l, model_r});

    // R2 R5 basic patterns, 16-clock slots
    send_frame(16'h8000, 16'h0001, 16, 16);
    send_frame(16'hFFFF, 16'h0000, 16, 16);
    send_frame(16'h1234, 16'hFEDC, 16, 16);

    // R6 word-select and data toggle with the bit clock still
    so_before = sd_o; l_before = left; r_before = right;
    for (int i = 0; i < 12; i++) begin
      ws = ~ws; sd = ~sd;
      repeat (3) @(negedge clk);
    end
    ws = 1'b1; sd = 1'b0;
    repeat (6) @(negedge clk);
    check("R6 sd_o unchanged", 32'(sd_o), 32'(so_before));
    check("R6 left unchanged", 32'(left), 32'(l_before));
    check("R6 right unchanged", 32'(right), 32'(r_before));

    // R4 long slots: trailing bits ignored, transmit pads zeros
    send_frame(16'hC0DE, 16'hBEEF, 24, 24);
    send_frame(16'h5555, 16'hAAAA, 16, 32);

    // R7 short slot then recovery
    send_frame(16'hF00F, 16'h0FF0, 10, 16);
    send_frame(16'h1357, 16'h2468, 16, 16);
    for (int i = 1; i < 4; i++) begin
      send_frame(16'(i * 16'h1111) ^ 16'h0F0F, 16'(i * 16'h2345), 16, 16);
    end

    // trailing slot start closes the last frame
    drive_slot(1'b0, 16'h0000, 2, model_l);
    repeat (20) @(negedge clk);
    check("R3 one strobe per frame", 32'(exp_q.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule